// File: doc/BRIEF.md
# Boot Alias Selector and Address Remapper

This block decides which memory answers at the bottom of the CPU address space and turns CPU addresses in that low window into physical addresses. Two boot-select pins are captured on the first clock edge after reset is released. They are captured again on every standby-exit pulse. The captured code picks main flash, system flash or SRAM as the memory that is aliased at address zero.

Software can later change the aliased memory by writing a 2-bit code through a one-cycle write strobe. A CPU address whose upper bits are all zero lies in the 64 KiB alias window. Such an address is rebased onto the selected memory's physical region. Every other address passes through unchanged, so each memory also stays reachable at its own physical address. The translation is combinational.

Top module: `boot_alias_remap`

## Requirements
- R1: On the first rising clock edge after rst_ni is released, alias_sel_o loads a code from the pins: 2'b00 (main flash) when boot0_i=0, whatever boot1_i is; 2'b01 (system flash) when boot0_i=1 and boot1_i=0; 2'b11 (SRAM) when both are 1. While rst_ni is low, alias_sel_o reads 2'b00.
- R2: Outside a capture edge, changes on boot0_i and boot1_i do not alter alias_sel_o.
- R3: A rising edge with stby_exit_i=1 re-captures the pins with the R1 encoding, and the new code shows on alias_sel_o after that edge. This capture replaces any earlier software value. It also wins over a register write in the same cycle.
- R4: A rising edge with reg_we_i=1 and reg_wdata_i equal to 2'b00, 2'b01 or 2'b11 loads that code into alias_sel_o, visible after that edge, unless a capture is due on that edge.
- R5: A write with reg_wdata_i=2'b10 is ignored, and alias_sel_o keeps its value.
- R6: With selection 2'b00, an address with bits [31:16] all zero maps to 0x0800_0000 plus bits [15:0].
- R7: With selection 2'b01, an alias-window address maps to 0x1FFF_0000 plus bits [15:0].
- R8: With selection 2'b11, an alias-window address maps to 0x2000_0000 plus bits [15:0].
- R9: An address with any of bits [31:16] set appears unchanged on phys_addr_o. This covers the physical addresses of all three memories.
- R10: phys_addr_o follows cpu_addr_i in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stby_exit_i | input | 1 | One-cycle pulse on exit from standby; re-captures the pins |
| boot0_i | input | 1 | Boot-select pin 0 |
| boot1_i | input | 1 | Boot-select pin 1 |
| reg_we_i | input | 1 | Remap register write strobe |
| reg_wdata_i | input | 2 | Remap code to write |
| cpu_addr_i | input | 32 | CPU address |
| phys_addr_o | output | 32 | Translated physical address |
| alias_sel_o | output | 2 | Current alias selection code |

## Verification
The hardest case to reach is a standby-exit pulse and a software write landing on the same edge. Only the capture priority decides what remains there. The bench first moves the selection away from the pin value by a software write. It then raises stby_exit_i and reg_we_i together, with pins and write data that point to different memories, and checks that the pin code is the one that stays. A second hard case is a pin change that must be ignored. The bench toggles the pins over several idle cycles between captures and reads the selection through address translation as well as through alias_sel_o.

// File: rtl/boot_alias_pkg.sv
package boot_alias_pkg;

  typedef enum logic [1:0] {
    SEL_MAIN = 2'b00,
    SEL_SYS  = 2'b01,
    SEL_SRAM = 2'b11
  } alias_sel_e;

  function automatic alias_sel_e pins_to_sel(input logic b0, input logic b1);
    if (!b0)     return SEL_MAIN;
    else if (b1) return SEL_SRAM;
    else         return SEL_SYS;
  endfunction

  function automatic logic sel_code_legal(input logic [1:0] code);
    return code != 2'b10;
  endfunction

endpackage

// File: rtl/boot_sel_ctrl.sv
module boot_sel_ctrl
  import boot_alias_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_exit_i,
  input  logic       boot0_i,
  input  logic       boot1_i,
  input  logic       reg_we_i,
  input  logic [1:0] reg_wdata_i,
  output alias_sel_e sel_o,
  output logic       cap_pend_o
);

  alias_sel_e sel_q;
  logic       pend_q;
  logic       capture;

  // capture on first edge out of reset or on standby exit; beats sw write
  assign capture = pend_q | stby_exit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
      sel_q  <= SEL_MAIN;
    end else begin
      pend_q <= 1'b0;
      if (capture)
        sel_q <= pins_to_sel(boot0_i, boot1_i);
      else if (reg_we_i && sel_code_legal(reg_wdata_i))
        sel_q <= alias_sel_e'(reg_wdata_i);
    end
  end

  assign sel_o      = sel_q;
  assign cap_pend_o = pend_q;

endmodule

// File: rtl/alias_xlate.sv
module alias_xlate
  import boot_alias_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        WIN_BITS  = 16,
  parameter logic [ADDR_W-1:0]  MAIN_BASE = 'h0800_0000,
  parameter logic [ADDR_W-1:0]  SYS_BASE  = 'h1FFF_0000,
  parameter logic [ADDR_W-1:0]  SRAM_BASE = 'h2000_0000
) (
  input  alias_sel_e        sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned HI_W = ADDR_W - WIN_BITS;

  logic                in_win;
  logic [ADDR_W-1:0]   base;
  logic [ADDR_W-1:0]   offs;

  assign in_win = (addr_i[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});
  assign offs   = {{HI_W{1'b0}}, addr_i[WIN_BITS-1:0]};

  always_comb begin
    unique case (sel_i)
      SEL_SYS:  base = SYS_BASE;
      SEL_SRAM: base = SRAM_BASE;
      default:  base = MAIN_BASE;
    endcase
  end

  assign addr_o = in_win ? (base + offs) : addr_i;

endmodule

// File: rtl/boot_alias_remap.sv
module boot_alias_remap
  import boot_alias_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        WIN_BITS  = 16,
  parameter logic [ADDR_W-1:0]  MAIN_BASE = 'h0800_0000,
  parameter logic [ADDR_W-1:0]  SYS_BASE  = 'h1FFF_0000,
  parameter logic [ADDR_W-1:0]  SRAM_BASE = 'h2000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stby_exit_i,
  input  logic              boot0_i,
  input  logic              boot1_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_wdata_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic [1:0]        alias_sel_o
);

  alias_sel_e sel;
  logic       cap_pend_q;

  boot_sel_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stby_exit_i (stby_exit_i),
    .boot0_i     (boot0_i),
    .boot1_i     (boot1_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .sel_o       (sel),
    .cap_pend_o  (cap_pend_q)
  );

  alias_xlate #(
    .ADDR_W    (ADDR_W),
    .WIN_BITS  (WIN_BITS),
    .MAIN_BASE (MAIN_BASE),
    .SYS_BASE  (SYS_BASE),
    .SRAM_BASE (SRAM_BASE)
  ) u_xlate (
    .sel_i  (sel),
    .addr_i (cpu_addr_i),
    .addr_o (phys_addr_o)
  );

  assign alias_sel_o = sel;

endmodule

// File: rtl/boot_alias_chk.sv
module boot_alias_chk
  import boot_alias_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stby_exit_i,
  input logic              boot0_i,
  input logic              boot1_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_wdata_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [ADDR_W-1:0] phys_addr_o,
  input logic [1:0]        alias_sel_o,
  input logic              cap_pend_q
);

  localparam int unsigned HI_W = ADDR_W - WIN_BITS;

  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_pend_q && !stby_exit_i && !reg_we_i) |=> $stable(alias_sel_o)); // R2

  AST_BOOT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_pend_q |=> alias_sel_o == 2'(pins_to_sel($past(boot0_i), $past(boot1_i)))); // R1

  AST_STBY_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_exit_i |=> alias_sel_o == 2'(pins_to_sel($past(boot0_i), $past(boot1_i)))); // R3

  AST_SW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !stby_exit_i && !cap_pend_q && reg_wdata_i != 2'b10)
      |=> alias_sel_o == $past(reg_wdata_i)); // R4

  AST_NO_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_sel_o != 2'b10); // R5

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[ADDR_W-1:WIN_BITS] != {HI_W{1'b0}}) |-> phys_addr_o == cpu_addr_i); // R9

  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}})
      |-> phys_addr_o[WIN_BITS-1:0] == cpu_addr_i[WIN_BITS-1:0]); // R10

endmodule

bind boot_alias_remap boot_alias_chk #(
  .ADDR_W   (ADDR_W),
  .WIN_BITS (WIN_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stby_exit_i (stby_exit_i),
  .boot0_i     (boot0_i),
  .boot1_i     (boot1_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .cpu_addr_i  (cpu_addr_i),
  .phys_addr_o (phys_addr_o),
  .alias_sel_o (alias_sel_o),
  .cap_pend_q  (cap_pend_q)
);

// File: tb/boot_alias_remap_tb.sv
module boot_alias_remap_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stby_exit_i = 1'b0;
  logic        boot0_i = 1'b0;
  logic        boot1_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_wdata_i = 2'b00;
  logic [31:0] cpu_addr_i = 32'h0;
  logic [31:0] phys_addr_o;
  logic [1:0]  alias_sel_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  boot_alias_remap dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stby_exit_i (stby_exit_i),
    .boot0_i     (boot0_i),
    .boot1_i     (boot1_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .cpu_addr_i  (cpu_addr_i),
    .phys_addr_o (phys_addr_o),
    .alias_sel_o (alias_sel_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change at negedge; results sampled at the following negedge
  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] base_of(input logic [1:0] s);
    case (s)
      2'b01:   return 32'h1FFF_0000;
      2'b11:   return 32'h2000_0000;
      default: return 32'h0800_0000;
    endcase
  endfunction

  task automatic do_reset(input logic b0, input logic b1, input logic [1:0] exp);
    @(negedge clk_i);
    rst_ni = 1'b0;
    boot0_i = b0; boot1_i = b1;
    cpu_addr_i = 32'h0000_1234;
    #1;
    check("R1 reset sel", {30'b0, alias_sel_o}, 32'h0);
    check("R6 reset xlate", phys_addr_o, 32'h0800_1234);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    check("R1 boot capture", {30'b0, alias_sel_o}, {30'b0, exp});
  endtask

  task automatic t_reset_codes();
    do_reset(1'b0, 1'b1, 2'b00);
    do_reset(1'b1, 1'b0, 2'b01);
    do_reset(1'b1, 1'b1, 2'b11);
    do_reset(1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_pin_ignore();
    do_reset(1'b1, 1'b0, 2'b01);
    for (int i = 0; i < 4; i++) begin
      boot0_i = i[0]; boot1_i = ~i[1];
      tick();
      check("R2 pins ignored", {30'b0, alias_sel_o}, 32'h1);
    end
    cpu_addr_i = 32'h0000_0040;
    #1;
    check("R2 pins ignored xlate", phys_addr_o, 32'h1FFF_0040);
  endtask

  task automatic t_xlate_all();
    logic [1:0] codes [3] = '{2'b00, 2'b01, 2'b11};
    logic [31:0] offs [3] = '{32'h0000_0000, 32'h0000_0004, 32'h0000_FFFF};
    for (int c = 0; c < 3; c++) begin
      reg_we_i = 1'b1; reg_wdata_i = codes[c];
      tick();
      reg_we_i = 1'b0;
      check("R4 sw write", {30'b0, alias_sel_o}, {30'b0, codes[c]});
      for (int k = 0; k < 3; k++) begin
        cpu_addr_i = offs[k];
        #1;
        if (codes[c] == 2'b00)      check("R6 main alias", phys_addr_o, base_of(codes[c]) + offs[k]);
        else if (codes[c] == 2'b01) check("R7 sys alias", phys_addr_o, base_of(codes[c]) + offs[k]);
        else                        check("R8 sram alias", phys_addr_o, base_of(codes[c]) + offs[k]);
      end
    end
  endtask

  task automatic t_passthru();
    logic [31:0] a [5] = '{32'h0001_0000, 32'h0800_0010, 32'h1FFF_0200, 32'h2000_3000, 32'hFFFF_FFFF};
    for (int k = 0; k < 5; k++) begin
      cpu_addr_i = a[k];
      #1;
      check("R9 pass-through", phys_addr_o, a[k]);
    end
    // R10: change address mid-cycle, no edge in between
    @(posedge clk_i); #3;
    cpu_addr_i = 32'h0000_0100;
    #1;
    check("R10 comb", phys_addr_o, base_of(alias_sel_o) + 32'h100);
    @(negedge clk_i);
  endtask

  task automatic t_bad_write();
    reg_we_i = 1'b1; reg_wdata_i = 2'b11;
    tick();
    reg_wdata_i = 2'b10;
    tick();
    reg_we_i = 1'b0;
    check("R5 illegal write ignored", {30'b0, alias_sel_o}, 32'h3);
    cpu_addr_i = 32'h0000_0008;
    #1;
    check("R5 xlate unchanged", phys_addr_o, 32'h2000_0008);
  endtask

  task automatic t_stby();
    boot0_i = 1'b1; boot1_i = 1'b0;
    reg_we_i = 1'b1; reg_wdata_i = 2'b11;
    tick();
    reg_we_i = 1'b0;
    check("R4 pre-stby sw", {30'b0, alias_sel_o}, 32'h3);
    stby_exit_i = 1'b1;
    tick();
    stby_exit_i = 1'b0;
    check("R3 stby overrides sw", {30'b0, alias_sel_o}, 32'h1);
    // same-edge: stby wins over write
    boot0_i = 1'b0; boot1_i = 1'b1;
    stby_exit_i = 1'b1; reg_we_i = 1'b1; reg_wdata_i = 2'b11;
    tick();
    stby_exit_i = 1'b0; reg_we_i = 1'b0;
    check("R3 stby beats write", {30'b0, alias_sel_o}, 32'h0);
    boot0_i = 1'b1; boot1_i = 1'b1;
    stby_exit_i = 1'b1;
    tick();
    stby_exit_i = 1'b0;
    check("R3 stby sram", {30'b0, alias_sel_o}, 32'h3);
    boot0_i = 1'b0;
    tick();
    check("R2 after stby", {30'b0, alias_sel_o}, 32'h3);
  endtask

  initial begin
    t_reset_codes();
    t_pin_ignore();
    t_xlate_all();
    t_passthru();
    t_bad_write();
    t_stby();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule